// File: doc/BRIEF.md
# External Interrupt Priority Arbiter

This block gathers every pending external-interruption condition for one processor and, each time the processor asks, presents exactly one of them. The sources are an interrupt key, a malfunction-alert bitmap and an emergency-signal bitmap (each indexed by the sending processor, each with a summary flag), an external call with the caller's address, a clock comparison, a sign test on a CPU timer, an interval-timer request and a service signal with a parameter word. A per-source enable mask, a global external enable and a guest-mode flag gate the scan.

A request is sampled on a clock edge. The chosen condition appears one cycle later as a single-cycle take strobe, together with a 3-bit code, an originator address, a parameter word and the clear pulses the owner of each pending flag must apply. Conditions that are not chosen are left alone and can be taken on later requests. Writing status words to memory belongs to the consumer of the strobe.

Top module: `ext_irq_arbiter`

## Requirements
- R1: A request is accepted when `eval_req` and `ext_enable` are both high at a clock edge and no request was accepted at the previous edge. The result (strobe, code, address, parameter, clears) is driven for exactly the next cycle. Every output is zero in all other cycles.
- R2: At most one condition is taken per accepted request. The scan order from first to last, with the code reported in `take_code`, is: interrupt key 0, malfunction alert 1, emergency signal 2, external call 3, clock comparator 4, CPU timer 5, interval timer 6, service signal 7.
- R3: Bit n of `src_mask` enables the source whose code is n. A source whose bit is clear is skipped, and it gets no clear pulse.
- R4: While `guest_mode` is high, the interrupt key and the service signal are treated as not pending.
- R5: For malfunction alert and emergency signal, the lowest-numbered set bit of the bitmap is served. Exactly that bit is pulsed in the matching clear vector.
- R6: When a bitmap class is taken, its summary clear pulse is issued only if no higher-numbered bit of that bitmap is set.
- R7: A bitmap class whose summary flag is set and enabled while its bitmap is all zero ends the scan. It pulses its summary clear, produces no strobe, and lets no later source be taken.
- R8: The clock comparator is pending only when `tod_value` is strictly greater than `clkc_value` (unsigned). The CPU timer is pending when `cpu_timer` read as two's complement is negative.
- R9: `take_addr` is `xcall_addr` for an external call and the sender index for an emergency signal. It is zero for every other code, malfunction alert included.
- R10: Taking the interrupt key, external call, interval timer or service signal pulses its own clear. Clock comparator and CPU timer pulse no clear. `take_parm` is `svc_parm` for a service signal and zero otherwise.
- R11: While `rst_n` is low at a clock edge, every output is zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| eval_req | input | 1 | Processor asks for an interruption |
| ext_enable | input | 1 | Global external-interruption enable |
| guest_mode | input | 1 | Processor runs as a guest |
| src_mask | input | 8 | Per-source enable, bit n for code n |
| key_pend | input | 1 | Interrupt-key pending |
| malf_pend | input | 1 | Malfunction-alert summary flag |
| malf_map | input | SENDERS | Malfunction-alert sender bitmap |
| emer_pend | input | 1 | Emergency-signal summary flag |
| emer_map | input | SENDERS | Emergency-signal sender bitmap |
| xcall_pend | input | 1 | External-call pending |
| xcall_addr | input | ADDR_W | Address of the external caller |
| tod_value | input | TIME_W | Time-of-day value |
| clkc_value | input | TIME_W | Clock comparator value |
| cpu_timer | input | TIME_W | CPU timer, two's complement |
| itmr_pend | input | 1 | Interval-timer pending |
| svc_pend | input | 1 | Service-signal pending |
| svc_parm | input | PARM_W | Service-signal parameter |
| take | output | 1 | One-cycle take strobe |
| take_code | output | 3 | Code of the taken condition |
| take_addr | output | ADDR_W | Originator address |
| take_parm | output | PARM_W | Parameter word |
| clr_key | output | 1 | Clear interrupt-key pending |
| clr_malf_sum | output | 1 | Clear malfunction-alert summary |
| clr_malf_bit | output | SENDERS | Clear one malfunction-alert sender bit |
| clr_emer_sum | output | 1 | Clear emergency-signal summary |
| clr_emer_bit | output | SENDERS | Clear one emergency-signal sender bit |
| clr_xcall | output | 1 | Clear external-call pending |
| clr_itmr | output | 1 | Clear interval-timer pending |
| clr_svc | output | 1 | Clear service-signal pending |

## Verification
The bench targets a bitmap with several bits set, where a design that picks the wrong end would serve the highest sender or drop the summary flag too early. A single top bit should drop the summary, and a design that keeps it would present a phantom interruption later. It also sets a summary flag over an empty bitmap beside a lower-priority pending source; a design that goes on scanning would take that source early. A time-of-day equal to the comparator must not fire, which catches a greater-or-equal compare. Guest mode and masked sources must leave their conditions pending with no clear pulse, and two requests on consecutive edges must yield one strobe, not a double take on stale flags.

// File: rtl/ext_arb_pkg.sv
// Package: shared codes and source count for the external interrupt arbiter.
// Assumes: the code value equals the source's position in the scan and its mask bit.
package ext_arb_pkg;

    localparam int unsigned NUM_SRC = 8;

    typedef enum logic [2:0] {
        EXC_KEY   = 3'd0,
        EXC_MALF  = 3'd1,
        EXC_EMER  = 3'd2,
        EXC_XCALL = 3'd3,
        EXC_CLKC  = 3'd4,
        EXC_CPUT  = 3'd5,
        EXC_ITMR  = 3'd6,
        EXC_SVC   = 3'd7
    } ext_code_e;

endpackage

// File: rtl/ext_arb_lowbit.sv
// Module: finds the lowest set bit of a sender bitmap.
// Gives a one-hot of that bit and says whether any other bit is set.
// Assumes: purely combinational; the depth is a ripple of N OR gates.
module ext_arb_lowbit #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] map,
    output logic         found,
    output logic [N-1:0] first_oh,
    output logic         rest_any
);

    // below[i]: some bit under position i is set
    logic [N:0] below;

    assign below[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_scan
            assign below[i+1]  = below[i] | map[i];
            assign first_oh[i] = map[i] & ~below[i];
        end
    endgenerate

    assign found    = below[N];
    assign rest_any = |(map & ~first_oh);

endmodule

// File: rtl/ext_arb_prio.sv
// Module: combinational priority scan over the eight external sources.
// Works out the next take, code, address, parameter and clear pulses.
// Assumes: its inputs are stable at the sampling edge; the caller registers the result.
module ext_arb_prio
    import ext_arb_pkg::*;
#(
    parameter int unsigned SENDERS = 8,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned TIME_W  = 64,
    parameter int unsigned PARM_W  = 32
) (
    input  logic                guest_mode,
    input  logic [NUM_SRC-1:0]  src_mask,
    input  logic                key_pend,
    input  logic                malf_pend,
    input  logic [SENDERS-1:0]  malf_map,
    input  logic                emer_pend,
    input  logic [SENDERS-1:0]  emer_map,
    input  logic                xcall_pend,
    input  logic [ADDR_W-1:0]   xcall_addr,
    input  logic [TIME_W-1:0]   tod_value,
    input  logic [TIME_W-1:0]   clkc_value,
    input  logic [TIME_W-1:0]   cpu_timer,
    input  logic                itmr_pend,
    input  logic                svc_pend,
    input  logic [PARM_W-1:0]   svc_parm,
    output logic                nx_take,
    output logic [2:0]          nx_code,
    output logic [ADDR_W-1:0]   nx_addr,
    output logic [PARM_W-1:0]   nx_parm,
    output logic                nx_clr_key,
    output logic                nx_clr_malf_sum,
    output logic [SENDERS-1:0]  nx_clr_malf_bit,
    output logic                nx_clr_emer_sum,
    output logic [SENDERS-1:0]  nx_clr_emer_bit,
    output logic                nx_clr_xcall,
    output logic                nx_clr_itmr,
    output logic                nx_clr_svc
);

    localparam int unsigned IDX_W = (SENDERS > 1) ? $clog2(SENDERS) : 1;

    logic               malf_found, malf_rest;
    logic [SENDERS-1:0] malf_oh;
    logic               emer_found, emer_rest;
    logic [SENDERS-1:0] emer_oh;
    logic [IDX_W-1:0]   emer_idx;

    ext_arb_lowbit #(.N(SENDERS)) u_malf_pick (
        .map      (malf_map),
        .found    (malf_found),
        .first_oh (malf_oh),
        .rest_any (malf_rest)
    );

    ext_arb_lowbit #(.N(SENDERS)) u_emer_pick (
        .map      (emer_map),
        .found    (emer_found),
        .first_oh (emer_oh),
        .rest_any (emer_rest)
    );

    // Encode the chosen emergency sender's one-hot into its index
    always_comb begin
        emer_idx = '0;
        for (int i = 0; i < SENDERS; i++) begin
            if (emer_oh[i]) emer_idx = emer_idx | IDX_W'(i);
        end
    end

    logic act_key, act_malf, act_emer, act_xcall;
    logic act_clkc, act_cput, act_itmr, act_svc;

    assign act_key   = key_pend   & src_mask[EXC_KEY]   & ~guest_mode;
    assign act_malf  = malf_pend  & src_mask[EXC_MALF];
    assign act_emer  = emer_pend  & src_mask[EXC_EMER];
    assign act_xcall = xcall_pend & src_mask[EXC_XCALL];
    assign act_clkc  = (tod_value > clkc_value) & src_mask[EXC_CLKC];
    assign act_cput  = ($signed(cpu_timer) < 0) & src_mask[EXC_CPUT];
    assign act_itmr  = itmr_pend  & src_mask[EXC_ITMR];
    assign act_svc   = svc_pend   & src_mask[EXC_SVC] & ~guest_mode;

    // Walk the sources in fixed order and build the result of the first active one
    always_comb begin
        nx_take         = 1'b0;
        nx_code         = EXC_KEY;
        nx_addr         = '0;
        nx_parm         = '0;
        nx_clr_key      = 1'b0;
        nx_clr_malf_sum = 1'b0;
        nx_clr_malf_bit = '0;
        nx_clr_emer_sum = 1'b0;
        nx_clr_emer_bit = '0;
        nx_clr_xcall    = 1'b0;
        nx_clr_itmr     = 1'b0;
        nx_clr_svc      = 1'b0;
        if (act_key) begin
            nx_take    = 1'b1;
            nx_code    = EXC_KEY;
            nx_clr_key = 1'b1;
        end else if (act_malf) begin
            if (malf_found) begin
                nx_take         = 1'b1;
                nx_code         = EXC_MALF;
                nx_clr_malf_bit = malf_oh;
                nx_clr_malf_sum = ~malf_rest;
            end else begin
                nx_clr_malf_sum = 1'b1;
            end
        end else if (act_emer) begin
            if (emer_found) begin
                nx_take         = 1'b1;
                nx_code         = EXC_EMER;
                nx_addr         = ADDR_W'(emer_idx);
                nx_clr_emer_bit = emer_oh;
                nx_clr_emer_sum = ~emer_rest;
            end else begin
                nx_clr_emer_sum = 1'b1;
            end
        end else if (act_xcall) begin
            nx_take      = 1'b1;
            nx_code      = EXC_XCALL;
            nx_addr      = xcall_addr;
            nx_clr_xcall = 1'b1;
        end else if (act_clkc) begin
            nx_take = 1'b1;
            nx_code = EXC_CLKC;
        end else if (act_cput) begin
            nx_take = 1'b1;
            nx_code = EXC_CPUT;
        end else if (act_itmr) begin
            nx_take     = 1'b1;
            nx_code     = EXC_ITMR;
            nx_clr_itmr = 1'b1;
        end else if (act_svc) begin
            nx_take    = 1'b1;
            nx_code    = EXC_SVC;
            nx_parm    = svc_parm;
            nx_clr_svc = 1'b1;
        end
    end

endmodule

// File: rtl/ext_irq_arbiter.sv
// Module: top of the external interrupt arbiter.
// Samples a request, runs the priority scan and registers a one-cycle result.
// Assumes: the owners of the pending flags apply the clear pulses at the edge
// that ends the strobe cycle; a request on the edge straight after an accepted
// one is not evaluated, so it never sees flags that are about to be cleared.
module ext_irq_arbiter
    import ext_arb_pkg::*;
#(
    parameter int unsigned SENDERS = 8,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned TIME_W  = 64,
    parameter int unsigned PARM_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                eval_req,
    input  logic                ext_enable,
    input  logic                guest_mode,
    input  logic [NUM_SRC-1:0]  src_mask,
    input  logic                key_pend,
    input  logic                malf_pend,
    input  logic [SENDERS-1:0]  malf_map,
    input  logic                emer_pend,
    input  logic [SENDERS-1:0]  emer_map,
    input  logic                xcall_pend,
    input  logic [ADDR_W-1:0]   xcall_addr,
    input  logic [TIME_W-1:0]   tod_value,
    input  logic [TIME_W-1:0]   clkc_value,
    input  logic [TIME_W-1:0]   cpu_timer,
    input  logic                itmr_pend,
    input  logic                svc_pend,
    input  logic [PARM_W-1:0]   svc_parm,
    output logic                take,
    output logic [2:0]          take_code,
    output logic [ADDR_W-1:0]   take_addr,
    output logic [PARM_W-1:0]   take_parm,
    output logic                clr_key,
    output logic                clr_malf_sum,
    output logic [SENDERS-1:0]  clr_malf_bit,
    output logic                clr_emer_sum,
    output logic [SENDERS-1:0]  clr_emer_bit,
    output logic                clr_xcall,
    output logic                clr_itmr,
    output logic                clr_svc
);

    logic               nx_take;
    logic [2:0]         nx_code;
    logic [ADDR_W-1:0]  nx_addr;
    logic [PARM_W-1:0]  nx_parm;
    logic               nx_clr_key, nx_clr_malf_sum, nx_clr_emer_sum;
    logic [SENDERS-1:0] nx_clr_malf_bit, nx_clr_emer_bit;
    logic               nx_clr_xcall, nx_clr_itmr, nx_clr_svc;

    logic eval_go;
    logic eval_go_q;

    ext_arb_prio #(
        .SENDERS (SENDERS),
        .ADDR_W  (ADDR_W),
        .TIME_W  (TIME_W),
        .PARM_W  (PARM_W)
    ) u_prio (
        .guest_mode      (guest_mode),
        .src_mask        (src_mask),
        .key_pend        (key_pend),
        .malf_pend       (malf_pend),
        .malf_map        (malf_map),
        .emer_pend       (emer_pend),
        .emer_map        (emer_map),
        .xcall_pend      (xcall_pend),
        .xcall_addr      (xcall_addr),
        .tod_value       (tod_value),
        .clkc_value      (clkc_value),
        .cpu_timer       (cpu_timer),
        .itmr_pend       (itmr_pend),
        .svc_pend        (svc_pend),
        .svc_parm        (svc_parm),
        .nx_take         (nx_take),
        .nx_code         (nx_code),
        .nx_addr         (nx_addr),
        .nx_parm         (nx_parm),
        .nx_clr_key      (nx_clr_key),
        .nx_clr_malf_sum (nx_clr_malf_sum),
        .nx_clr_malf_bit (nx_clr_malf_bit),
        .nx_clr_emer_sum (nx_clr_emer_sum),
        .nx_clr_emer_bit (nx_clr_emer_bit),
        .nx_clr_xcall    (nx_clr_xcall),
        .nx_clr_itmr     (nx_clr_itmr),
        .nx_clr_svc      (nx_clr_svc)
    );

    // Accept a request only if the previous edge did not accept one
    assign eval_go = eval_req & ext_enable & ~eval_go_q;

    // Remember that a request was accepted, to block the next edge
    always_ff @(posedge clk) begin
        if (!rst_n) eval_go_q <= 1'b0;
        else        eval_go_q <= eval_go;
    end

    // Register the scan result for one cycle, zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !eval_go) begin
            take         <= 1'b0;
            take_code    <= '0;
            take_addr    <= '0;
            take_parm    <= '0;
            clr_key      <= 1'b0;
            clr_malf_sum <= 1'b0;
            clr_malf_bit <= '0;
            clr_emer_sum <= 1'b0;
            clr_emer_bit <= '0;
            clr_xcall    <= 1'b0;
            clr_itmr     <= 1'b0;
            clr_svc      <= 1'b0;
        end else begin
            take         <= nx_take;
            take_code    <= nx_code;
            take_addr    <= nx_addr;
            take_parm    <= nx_parm;
            clr_key      <= nx_clr_key;
            clr_malf_sum <= nx_clr_malf_sum;
            clr_malf_bit <= nx_clr_malf_bit;
            clr_emer_sum <= nx_clr_emer_sum;
            clr_emer_bit <= nx_clr_emer_bit;
            clr_xcall    <= nx_clr_xcall;
            clr_itmr     <= nx_clr_itmr;
            clr_svc      <= nx_clr_svc;
        end
    end

endmodule

// File: rtl/ext_irq_arbiter_chk.sv
// Module: assertion checker for ext_irq_arbiter, attached by bind.
// Assumes: same parameters as the arbiter; only observes its ports.
module ext_irq_arbiter_chk
    import ext_arb_pkg::*;
#(
    parameter int unsigned SENDERS = 8,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned TIME_W  = 64,
    parameter int unsigned PARM_W  = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                eval_req,
    input logic                ext_enable,
    input logic                guest_mode,
    input logic [NUM_SRC-1:0]  src_mask,
    input logic [SENDERS-1:0]  malf_map,
    input logic [SENDERS-1:0]  emer_map,
    input logic [ADDR_W-1:0]   xcall_addr,
    input logic [TIME_W-1:0]   tod_value,
    input logic [TIME_W-1:0]   clkc_value,
    input logic                take,
    input logic [2:0]          take_code,
    input logic [ADDR_W-1:0]   take_addr,
    input logic                clr_key,
    input logic                clr_malf_sum,
    input logic [SENDERS-1:0]  clr_malf_bit,
    input logic                clr_emer_sum,
    input logic [SENDERS-1:0]  clr_emer_bit,
    input logic                clr_xcall,
    input logic                clr_itmr,
    input logic                clr_svc
);

    p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

    p_take_needs_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(eval_req && ext_enable));

    p_masked_not_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ((($past(src_mask)) >> take_code) & NUM_SRC'(1)) != '0);

    p_guest_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && $past(guest_mode)) |-> (take_code != EXC_KEY && take_code != EXC_SVC));

    p_one_sender_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_malf_bit) && $onehot0(clr_emer_bit));

    p_cleared_bit_was_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_emer_bit) |-> ((clr_emer_bit & $past(emer_map)) == clr_emer_bit));

    p_malf_bit_was_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_malf_bit) |-> ((clr_malf_bit & $past(malf_map)) == clr_malf_bit));

    p_clkc_strict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_code == EXC_CLKC) |-> ($past(tod_value) > $past(clkc_value)));

    p_addr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_code != EXC_XCALL && take_code != EXC_EMER) |-> (take_addr == '0));

    p_xcall_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_code == EXC_XCALL) |-> (take_addr == $past(xcall_addr)));

    p_level_no_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (take_code == EXC_CLKC || take_code == EXC_CPUT)) |->
        !(clr_key || clr_malf_sum || clr_emer_sum || clr_xcall || clr_itmr || clr_svc
          || (|clr_malf_bit) || (|clr_emer_bit)));

endmodule

bind ext_irq_arbiter ext_irq_arbiter_chk #(
    .SENDERS (SENDERS),
    .ADDR_W  (ADDR_W),
    .TIME_W  (TIME_W),
    .PARM_W  (PARM_W)
) u_chk (.*);

// File: tb/test_ext_irq_arbiter.sv
// Bench: random and directed stimulus against a reference scan model.
module test_ext_irq_arbiter;

    localparam int unsigned SENDERS = 8;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned TIME_W  = 64;
    localparam int unsigned PARM_W  = 32;
    localparam int unsigned OUT_W   = 66;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eval_req = 1'b0, ext_enable = 1'b0, guest_mode = 1'b0;
    logic [7:0] src_mask = '0;
    logic key_pend = 1'b0, malf_pend = 1'b0, emer_pend = 1'b0, xcall_pend = 1'b0;
    logic [SENDERS-1:0] malf_map = '0, emer_map = '0;
    logic [ADDR_W-1:0] xcall_addr = '0;
    logic [TIME_W-1:0] tod_value = '0, clkc_value = '0, cpu_timer = '0;
    logic itmr_pend = 1'b0, svc_pend = 1'b0;
    logic [PARM_W-1:0] svc_parm = '0;

    logic take;
    logic [2:0] take_code;
    logic [ADDR_W-1:0] take_addr;
    logic [PARM_W-1:0] take_parm;
    logic clr_key, clr_malf_sum, clr_emer_sum, clr_xcall, clr_itmr, clr_svc;
    logic [SENDERS-1:0] clr_malf_bit, clr_emer_bit;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ext_irq_arbiter #(
        .SENDERS(SENDERS), .ADDR_W(ADDR_W), .TIME_W(TIME_W), .PARM_W(PARM_W)
    ) i_ext_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .eval_req(eval_req), .ext_enable(ext_enable),
        .guest_mode(guest_mode), .src_mask(src_mask), .key_pend(key_pend),
        .malf_pend(malf_pend), .malf_map(malf_map), .emer_pend(emer_pend),
        .emer_map(emer_map), .xcall_pend(xcall_pend), .xcall_addr(xcall_addr),
        .tod_value(tod_value), .clkc_value(clkc_value), .cpu_timer(cpu_timer),
        .itmr_pend(itmr_pend), .svc_pend(svc_pend), .svc_parm(svc_parm),
        .take(take), .take_code(take_code), .take_addr(take_addr), .take_parm(take_parm),
        .clr_key(clr_key), .clr_malf_sum(clr_malf_sum), .clr_malf_bit(clr_malf_bit),
        .clr_emer_sum(clr_emer_sum), .clr_emer_bit(clr_emer_bit),
        .clr_xcall(clr_xcall), .clr_itmr(clr_itmr), .clr_svc(clr_svc)
    );

    logic [OUT_W-1:0] outv;
    assign outv = {take, take_code, take_addr, take_parm, clr_key, clr_malf_sum,
                   clr_malf_bit, clr_emer_sum, clr_emer_bit, clr_xcall, clr_itmr, clr_svc};

    // Reference scan written from the requirements
    function automatic logic [OUT_W-1:0] ref_model(input logic accepted);
        logic tk = 1'b0; logic [2:0] cd = '0; logic [ADDR_W-1:0] ad = '0;
        logic [PARM_W-1:0] pm = '0; logic ck = 1'b0, ms = 1'b0, es = 1'b0;
        logic cx = 1'b0, ci = 1'b0, cs = 1'b0;
        logic [SENDERS-1:0] mb = '0, eb = '0;
        logic done = 1'b0;
        int j;
        if (accepted) begin
            for (int s = 0; s < 8; s++) begin
                if (!done && src_mask[s]) begin
                    case (s)
                        0: if (key_pend && !guest_mode) begin done = 1; tk = 1; cd = 3'd0; ck = 1; end
                        1: if (malf_pend) begin
                               done = 1;
                               if (malf_map == '0) ms = 1;
                               else begin
                                   j = 0;
                                   for (int k = SENDERS - 1; k >= 0; k--) if (malf_map[k]) j = k;
                                   tk = 1; cd = 3'd1; mb = SENDERS'(1) << j;
                                   ms = ((malf_map >> (j + 1)) == '0);
                               end
                           end
                        2: if (emer_pend) begin
                               done = 1;
                               if (emer_map == '0) es = 1;
                               else begin
                                   j = 0;
                                   for (int k = SENDERS - 1; k >= 0; k--) if (emer_map[k]) j = k;
                                   tk = 1; cd = 3'd2; ad = ADDR_W'(j); eb = SENDERS'(1) << j;
                                   es = ((emer_map >> (j + 1)) == '0);
                               end
                           end
                        3: if (xcall_pend) begin done = 1; tk = 1; cd = 3'd3; ad = xcall_addr; cx = 1; end
                        4: if (tod_value > clkc_value) begin done = 1; tk = 1; cd = 3'd4; end
                        5: if (cpu_timer[TIME_W-1]) begin done = 1; tk = 1; cd = 3'd5; end
                        6: if (itmr_pend) begin done = 1; tk = 1; cd = 3'd6; ci = 1; end
                        default: if (svc_pend && !guest_mode) begin
                               done = 1; tk = 1; cd = 3'd7; pm = svc_parm; cs = 1;
                           end
                    endcase
                end
            end
        end
        return {tk, cd, ad, pm, ck, ms, mb, es, eb, cx, ci, cs};
    endfunction

    task automatic check(input string tag, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        ext_enable = 1'b1; guest_mode = 1'b0; src_mask = 8'hFF;
        key_pend = 0; malf_pend = 0; emer_pend = 0; xcall_pend = 0;
        malf_map = '0; emer_map = '0; xcall_addr = '0;
        tod_value = 64'd10; clkc_value = 64'd100; cpu_timer = 64'd5;
        itmr_pend = 0; svc_pend = 0; svc_parm = '0;
    endtask

    // One request: raise eval_req for one edge, check the cycle after it
    task automatic run_trial(input string tag);
        logic [OUT_W-1:0] exp;
        @(negedge clk);
        exp = ref_model(ext_enable);
        eval_req = 1'b1;
        @(negedge clk);
        eval_req = 1'b0;
        check(tag, outv, exp);
        @(negedge clk);
    endtask

    task automatic random_inputs();
        ext_enable = ($urandom % 8) != 0;
        guest_mode = ($urandom % 4) == 0;
        src_mask   = (($urandom % 3) == 0) ? 8'($urandom) : 8'hFF;
        key_pend   = ($urandom % 8) == 0;
        malf_pend  = ($urandom % 5) == 0;
        malf_map   = (($urandom % 4) == 0) ? '0 : SENDERS'($urandom & $urandom);
        emer_pend  = ($urandom % 4) == 0;
        emer_map   = (($urandom % 4) == 0) ? '0 : SENDERS'($urandom & $urandom);
        xcall_pend = ($urandom % 4) == 0;
        xcall_addr = ADDR_W'($urandom);
        tod_value  = {$urandom, $urandom};
        clkc_value = (($urandom % 4) == 0) ? tod_value : {$urandom, $urandom};
        cpu_timer  = {$urandom, $urandom};
        itmr_pend  = ($urandom % 3) == 0;
        svc_pend   = ($urandom % 2) == 0;
        svc_parm   = $urandom;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [OUT_W-1:0] exp;
        void'($urandom(32'd20240611));
        clear_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R11: outputs zero under reset
        check("R11 reset state", outv, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: everything pending, key wins
        clear_inputs();
        key_pend = 1; malf_pend = 1; malf_map = 8'h04; emer_pend = 1; emer_map = 8'h01;
        xcall_pend = 1; itmr_pend = 1; svc_pend = 1; tod_value = 64'd200;
        run_trial("R2 key first");

        // R4: guest mode hides key and service signal
        clear_inputs();
        guest_mode = 1; key_pend = 1; svc_pend = 1; svc_parm = 32'hDEAD_0001;
        run_trial("R4 guest hides key and service");

        // R3: masked key skipped, interval timer taken
        clear_inputs();
        src_mask = 8'hFE; key_pend = 1; itmr_pend = 1;
        run_trial("R3 masked key skipped");

        // R5 R6: lowest malfunction sender, summary kept, address zero (R9)
        clear_inputs();
        malf_pend = 1; malf_map = 8'b0010_1000;
        run_trial("R5 R6 lowest malfunction sender");

        // R6 R9: single top emergency sender drops summary, address 7
        clear_inputs();
        emer_pend = 1; emer_map = 8'b1000_0000;
        run_trial("R6 R9 last emergency sender");

        // R7: empty bitmap ends the scan, external call left waiting
        clear_inputs();
        emer_pend = 1; emer_map = '0; xcall_pend = 1; xcall_addr = 8'h5A;
        run_trial("R7 empty emergency bitmap");

        // R9: external call address
        clear_inputs();
        xcall_pend = 1; xcall_addr = 8'hC3;
        run_trial("R9 external call address");

        // R8: equal time does not fire the comparator
        clear_inputs();
        tod_value = 64'h1234_5678_9ABC_DEF0; clkc_value = 64'h1234_5678_9ABC_DEF0;
        run_trial("R8 equal comparator");
        tod_value = 64'h1234_5678_9ABC_DEF1;
        run_trial("R8 comparator one above");

        // R8: negative CPU timer
        clear_inputs();
        cpu_timer = 64'h8000_0000_0000_0000;
        run_trial("R8 negative CPU timer");

        // R10: service signal parameter and clear
        clear_inputs();
        svc_pend = 1; svc_parm = 32'hA5A5_0F0F;
        run_trial("R10 service parameter");

        // R1: global enable low gives nothing
        clear_inputs();
        ext_enable = 0; xcall_pend = 1;
        run_trial("R1 enable low");

        // R1: requests on two consecutive edges give one strobe
        clear_inputs();
        itmr_pend = 1;
        @(negedge clk);
        exp = ref_model(1'b1);
        eval_req = 1'b1;
        @(negedge clk);
        check("R1 first of back-to-back", outv, exp);
        @(negedge clk);
        eval_req = 1'b0;
        check("R1 second of back-to-back blocked", outv, '0);
        @(negedge clk);

        // R2: random mix
        for (int t = 0; t < 400; t++) begin
            random_inputs();
            run_trial("R2 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule